// File: doc/BRIEF.md
# Prescaled 64-bit Match Timer with Snapshot and Watchdog

This peripheral keeps a free-running 64-bit up-count that advances once every 2×(DIV+1) clocks, where DIV comes from a divider register. Six 32-bit compare channels watch the low half of the count. When the count steps onto a compare value, the channel raises a sticky flag. Software clears a flag by writing 1 to its bit. The flags, masked by per-channel enables, are ORed into a registered interrupt line.

A 64-bit value cannot be read tear-free through a 32-bit bus. Software therefore issues a snapshot command, which copies the whole count into two shadow words at a single clock edge, and then reads those words at leisure. Either half of the live count can be loaded by a write. A write to the low half also restarts the prescaler phase.

The last compare channel doubles as a watchdog. A small state machine handles it with three states:
- WD_OFF: the watchdog enable is clear.
- WD_ARMED: the enable is set and the machine waits for a channel-5 match.
- WD_FIRE: the reset pulse is being driven.

The transitions are:
- enable-set: WD_OFF to WD_ARMED.
- match-hit: WD_ARMED to WD_FIRE, which loads the pulse length.
- pulse-done: WD_FIRE back to WD_ARMED.
- disable: from any state to WD_OFF.

The reset output is driven only in WD_FIRE while the enable is still set.

Top module: `systimer_match64`

## Requirements
- R1: While reset is asserted, every register reads zero, and both irq_o and wdog_rst_o are low.
- R2: The count advances by one every 2×(DIV+1) clocks. A write to the counter-low word (byte 0x00) restarts the prescaler phase. k clocks after that write edge, the count has therefore advanced by floor(k/(2×(DIV+1))). The divider is at byte 0x2C.
- R3: Writes load the live count. Byte 0x00 loads the low half and byte 0x04 loads the high half. A load takes priority over an increment in the same cycle. An increment out of the low half carries into the high half.
- R4: A write to byte 0x30 with bit 0 = 1 copies the 64-bit count held just before that edge into the shadow words: low half at 0x34, high half at 0x38. A write there with bit 0 = 0 leaves the shadows unchanged.
- R5: Flag bit n (byte 0x20, n = 0..5) is set at the edge where a prescaler tick moves the low half onto compare n. Compare n is at byte 0x08 + 4n. Loading the count directly onto a compare value sets no flag, and a channel does not fire again until the low half comes round.
- R6: Flags are write-1-to-clear. A 0 bit in the written data leaves the flag as it was.
- R7: The enable word (byte 0x24) holds bits 5:0 and reads zero above them. irq_o is a register of OR(flag AND enable). It follows that term one clock late, and with an enable of zero it stays low.
- R8: When the watchdog enable (byte 0x28, bit 0) is set, a channel-5 match drives wdog_rst_o high for WDOG_PULSE clocks. The pulse starts at the same edge that sets flag 5.
- R9: When the watchdog enable is clear, a channel-5 match gives no pulse. Clearing the enable during a pulse ends the pulse at that write edge.
- R10: A read of an unmapped word returns zero, and a write to one compare word leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 1 | Registered interrupt request |
| wdog_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The assertions check the following on every cycle:
- The prescaler phase returns to zero after each tick.
- A load or snapshot lands on the next edge with the written value or the previous count.
- A flag never drops without a clear strobe, and it rises only on a tick.
- The watchdog machine leaves WD_FIRE at once when disabled, and its pulse only starts after a channel-5 hit.

Only the bench's scenarios can show the arithmetic of the count against elapsed clocks across a sweep of divider values, the carry between halves, the exact edge at which a flag and the interrupt appear, and the measured width of the watchdog pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int WORD_W = 32;
    localparam int NUM_CH = 6;
    localparam int WD_CH  = NUM_CH - 1;
    localparam int IDX_W  = 4;

    // word indices of the register map (byte address / 4)
    localparam logic [IDX_W-1:0] RI_CNT_LO  = 4'd0;
    localparam logic [IDX_W-1:0] RI_CNT_HI  = 4'd1;
    localparam logic [IDX_W-1:0] RI_CMP0    = 4'd2;
    localparam logic [IDX_W-1:0] RI_FLAGS   = 4'd8;
    localparam logic [IDX_W-1:0] RI_IEN     = 4'd9;
    localparam logic [IDX_W-1:0] RI_WDEN    = 4'd10;
    localparam logic [IDX_W-1:0] RI_PSC     = 4'd11;
    localparam logic [IDX_W-1:0] RI_SNAP    = 4'd12;
    localparam logic [IDX_W-1:0] RI_SNAP_LO = 4'd13;
    localparam logic [IDX_W-1:0] RI_SNAP_HI = 4'd14;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PW = DIV_W + 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] last_phase;

    // a period of 2*(div+1) clocks ends at phase 2*div+1
    assign last_phase = {div, 1'b1};
    assign tick       = (phase_q >= last_phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart || tick)
            phase_q <= '0;
        else
            phase_q <= phase_q + PW'(1);
    end

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase_q == '0));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> (phase_q == $past(phase_q) + PW'(1)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic                snap_req,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] cnt_o,
    output logic [2*WORD_W-1:0] snap_o,
    output logic [WORD_W-1:0]   next_lo
);
    localparam int CW = 2 * WORD_W;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] snap_q;

    assign cnt_o   = cnt_q;
    assign snap_o  = snap_q;
    assign next_lo = cnt_q[WORD_W-1:0] + WORD_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt_q[WORD_W-1:0]  <= wdata;
            if (ld_hi) cnt_q[CW-1:WORD_W] <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            snap_q <= '0;
        else if (snap_req)
            snap_q <= cnt_q;
    end

    // R3
    load_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (cnt_q[WORD_W-1:0] == $past(wdata)));

    // R4
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap_q == $past(cnt_q)));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_lo && !ld_hi) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [WORD_W-1:0] next_lo,
    input  logic [WORD_W-1:0] cmp,
    input  logic              clr,
    output logic              hit_o,
    output logic              flag_o
);
    logic flag_q;

    assign hit_o  = tick && (next_lo == cmp);
    assign flag_o = flag_q;

    // a new hit wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit_o)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

    // R5
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick));
endmodule

// File: rtl/tmr_wdog_fsm.sv
module tmr_wdog_fsm
    import tmr_pkg::*;
#(
    parameter int PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    output logic rst_o
);
    localparam int LW = $clog2(PULSE + 1);

    wd_state_t      state_q, state_d;
    logic [LW-1:0]  left_q, left_d;

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            WD_OFF: begin
                if (en) state_d = WD_ARMED;                 // enable-set
            end
            WD_ARMED: begin
                if (!en) begin
                    state_d = WD_OFF;                       // disable
                end else if (hit) begin
                    state_d = WD_FIRE;                      // match-hit
                    left_d  = LW'(PULSE - 1);
                end
            end
            WD_FIRE: begin
                if (!en)                state_d = WD_OFF;   // disable
                else if (left_q == '0)  state_d = WD_ARMED; // pulse-done
                else                    left_d  = left_q - LW'(1);
            end
            default: state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        rst_o = (state_q == WD_FIRE) && en;
    end

    // R9
    fire_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRE && !en) |=> (state_q == WD_OFF));

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_o) |-> $past(hit && en));
endmodule

// File: rtl/systimer_match64.sv
module systimer_match64
    import tmr_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DIV_W      = 32,
    parameter int WDOG_PULSE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              wdog_rst_o
);
    localparam int WA = ADDR_W - 2;

    logic [WA-1:0]        word_addr;
    logic                 in_map;
    logic [IDX_W-1:0]     idx;

    logic [WORD_W-1:0]    cmp_q [NUM_CH];
    logic [NUM_CH-1:0]    ien_q;
    logic                 wden_q;
    logic [DIV_W-1:0]     div_q;
    logic                 irq_q;

    logic                 tick;
    logic [2*WORD_W-1:0]  cnt;
    logic [2*WORD_W-1:0]  snap;
    logic [WORD_W-1:0]    next_lo;
    logic [NUM_CH-1:0]    hit;
    logic [NUM_CH-1:0]    flags;

    logic                 wr_lo, wr_hi, wr_flags, wr_ien, wr_wden, wr_psc, wr_snap;

    assign word_addr = bus_addr[ADDR_W-1:2];
    assign in_map    = ((word_addr >> IDX_W) == '0);
    assign idx       = word_addr[IDX_W-1:0];

    assign wr_lo    = bus_we && in_map && (idx == RI_CNT_LO);
    assign wr_hi    = bus_we && in_map && (idx == RI_CNT_HI);
    assign wr_flags = bus_we && in_map && (idx == RI_FLAGS);
    assign wr_ien   = bus_we && in_map && (idx == RI_IEN);
    assign wr_wden  = bus_we && in_map && (idx == RI_WDEN);
    assign wr_psc   = bus_we && in_map && (idx == RI_PSC);
    assign wr_snap  = bus_we && in_map && (idx == RI_SNAP) && bus_wdata[0];

    tmr_prescale #(.DIV_W(DIV_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_lo),
        .div     (div_q),
        .tick    (tick)
    );

    tmr_count #(.WORD_W(WORD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ld_lo    (wr_lo),
        .ld_hi    (wr_hi),
        .snap_req (wr_snap),
        .wdata    (bus_wdata[WORD_W-1:0]),
        .cnt_o    (cnt),
        .snap_o   (snap),
        .next_lo  (next_lo)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic wr_cmp;
        assign wr_cmp = bus_we && in_map && (idx == RI_CMP0 + IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cmp_q[g] <= '0;
            else if (wr_cmp)
                cmp_q[g] <= bus_wdata[WORD_W-1:0];
        end

        tmr_match_chan #(.WORD_W(WORD_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .next_lo (next_lo),
            .cmp     (cmp_q[g]),
            .clr     (wr_flags && bus_wdata[g]),
            .hit_o   (hit[g]),
            .flag_o  (flags[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wden_q <= 1'b0;
            div_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ien)  ien_q  <= bus_wdata[NUM_CH-1:0];
            if (wr_wden) wden_q <= bus_wdata[0];
            if (wr_psc)  div_q  <= bus_wdata[DIV_W-1:0];
            irq_q <= |(flags & ien_q);
        end
    end

    assign irq_o = irq_q;

    tmr_wdog_fsm #(.PULSE(WDOG_PULSE)) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wden_q),
        .hit   (hit[WD_CH]),
        .rst_o (wdog_rst_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            unique case (idx)
                RI_CNT_LO:  bus_rdata = cnt[WORD_W-1:0];
                RI_CNT_HI:  bus_rdata = cnt[2*WORD_W-1:WORD_W];
                RI_FLAGS:   bus_rdata = 32'(flags);
                RI_IEN:     bus_rdata = 32'(ien_q);
                RI_WDEN:    bus_rdata = 32'(wden_q);
                RI_PSC:     bus_rdata = 32'(div_q);
                RI_SNAP_LO: bus_rdata = snap[WORD_W-1:0];
                RI_SNAP_HI: bus_rdata = snap[2*WORD_W-1:WORD_W];
                default: begin
                    for (int i = 0; i < NUM_CH; i++)
                        if (idx == RI_CMP0 + IDX_W'(i)) bus_rdata = cmp_q[i];
                end
            endcase
        end
    end

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(flags != '0));

    // R9
    wdog_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_wden && !bus_wdata[0]) |=> !wdog_rst_o);
endmodule

// File: tb/systimer_match64_test.sv
module systimer_match64_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PULSE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        wdog_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    systimer_match64 #(.ADDR_W(6), .DIV_W(32), .WDOG_PULSE(PULSE)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_o      (irq_o),
        .wdog_rst_o (wdog_rst_o)
    );

    localparam logic [5:0] A_LO = 6'h00, A_HI = 6'h04, A_CMP0 = 6'h08, A_CMP1 = 6'h0C,
                           A_CMP2 = 6'h10, A_CMP3 = 6'h14, A_CMP5 = 6'h1C,
                           A_FLG = 6'h20, A_IEN = 6'h24, A_WDEN = 6'h28, A_PSC = 6'h2C,
                           A_SNAP = 6'h30, A_SLO = 6'h34, A_SHI = 6'h38, A_NONE = 6'h3C;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL timeout actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;

        // R1: all registers and outputs zero while reset is held
        repeat (3) @(negedge clk);
        for (int a = 0; a < 15; a++) begin
            rd(6'(a * 4), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", 32'(irq_o), 32'h0);
        chk("R1 reset wdog", 32'(wdog_rst_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: unmapped read, compare word isolation
        rd(A_NONE, v);
        chk("R10 unmapped read", v, 32'h0);
        wr(A_CMP3, 32'h0000ABCD);
        rd(A_CMP3, v);
        chk("R10 compare3 readback", v, 32'h0000ABCD);
        rd(A_CMP2, v);
        chk("R10 compare2 untouched", v, 32'h0);

        // R2 / R4: sweep divider and elapsed clocks, snapshot the count
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 13; k++) begin
                wr(A_PSC, 32'(d));
                wr(A_HI, 32'h0);
                wr(A_LO, 32'h0);
                idle(k);
                wr(A_SNAP, 32'h1);
                rd(A_SLO, v);
                chk("R2 R4 prescaled count", v, 32'(k / (2 * (d + 1))));
            end
        end

        // R3 / R4: carry from low to high half, coherent snapshot
        wr(A_PSC, 32'h0);
        wr(A_HI, 32'h5);
        wr(A_LO, 32'hFFFF_FFFE);
        idle(3);
        wr(A_SNAP, 32'h1);
        rd(A_SLO, v); chk("R3 snap low before carry", v, 32'hFFFF_FFFF);
        rd(A_SHI, v); chk("R3 snap high before carry", v, 32'h5);
        wr(A_SNAP, 32'h1);
        rd(A_SLO, v); chk("R3 snap low after carry", v, 32'h0);
        rd(A_SHI, v); chk("R3 snap high after carry", v, 32'h6);
        rd(A_HI, v);  chk("R3 live high half", v, 32'h6);
        wr(A_SNAP, 32'h0);
        rd(A_SLO, v); chk("R4 bit0 clear leaves snapshot", v, 32'h0);

        // R7: enable word width
        wr(A_IEN, 32'hFFFF_FFC1);
        rd(A_IEN, v);
        chk("R7 enable readback", v, 32'h1);
        wr(A_FLG, 32'h3F);
        rd(A_FLG, v);
        chk("R6 clear all flags", v, 32'h0);

        // R5: direct load onto a compare value does not fire
        wr(A_PSC, 32'd100);
        wr(A_CMP1, 32'd50);
        wr(A_LO, 32'd50);
        idle(2);
        rd(A_FLG, v);
        chk("R5 load onto compare no flag", v, 32'h0);

        // R5 / R6 / R7: channel 0 match, interrupt timing, clear
        wr(A_PSC, 32'h0);
        wr(A_CMP0, 32'd10);
        wr(A_IEN, 32'h1);
        wr(A_HI, 32'h0);
        wr(A_LO, 32'h0);
        idle(19);
        rd(A_FLG, v); chk("R5 flag before match edge", v, 32'h0);
        idle(1);
        rd(A_FLG, v); chk("R5 flag at match edge", v, 32'h1);
        chk("R7 irq one clock late", 32'(irq_o), 32'h0);
        idle(1);
        chk("R7 irq raised", 32'(irq_o), 32'h1);
        wr(A_FLG, 32'h0);
        rd(A_FLG, v); chk("R6 zero write keeps flag", v, 32'h1);
        wr(A_FLG, 32'h1);
        rd(A_FLG, v); chk("R6 one write clears flag", v, 32'h0);
        idle(1);
        chk("R7 irq dropped", 32'(irq_o), 32'h0);
        idle(10);
        rd(A_FLG, v); chk("R5 no refire before wrap", v, 32'h0);

        // R7: disabled channel keeps irq low
        wr(A_IEN, 32'h0);
        wr(A_LO, 32'h0);
        idle(20);
        rd(A_FLG, v); chk("R7 flag set while masked", v, 32'h1);
        idle(2);
        chk("R7 masked irq low", 32'(irq_o), 32'h0);

        // R8: watchdog pulse width
        wr(A_FLG, 32'h3F);
        wr(A_CMP5, 32'd4);
        wr(A_WDEN, 32'h1);
        wr(A_LO, 32'h0);
        idle(7);
        chk("R8 wdog before match", 32'(wdog_rst_o), 32'h0);
        idle(1);
        chk("R8 wdog starts with flag", 32'(wdog_rst_o), 32'h1);
        rd(A_FLG, v); chk("R8 flag5 set", v, 32'h20);
        idle(PULSE - 1);
        chk("R8 wdog last pulse clock", 32'(wdog_rst_o), 32'h1);
        idle(1);
        chk("R8 wdog pulse ended", 32'(wdog_rst_o), 32'h0);

        // R9: clearing enable ends pulse; disabled gives none
        wr(A_LO, 32'h0);
        idle(10);
        chk("R9 wdog mid pulse", 32'(wdog_rst_o), 32'h1);
        wr(A_WDEN, 32'h0);
        chk("R9 wdog cut by disable", 32'(wdog_rst_o), 32'h0);
        wr(A_FLG, 32'h3F);
        wr(A_LO, 32'h0);
        idle(8);
        rd(A_FLG, v); chk("R9 flag5 while disabled", v, 32'h20);
        chk("R9 no pulse while disabled", 32'(wdog_rst_o), 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule